// File: doc/BRIEF.md
# Cascaded Board Interrupt Aggregator

This block gathers sixteen board-level interrupt requests into one level-sensitive cascade line that feeds a primary interrupt controller. Each request source owns one bit position in every register: source k is bit k. A source can only record an event when software has enabled it, and a recorded event only reaches the cascade line when software has also unmasked it.

Software reaches the block over a small 16-bit register bus with single-cycle write strobes and registered reads. Enable and mask are each written through a pair of ports, one that sets bits and one that clears bits, so no read-modify-write is needed. A service routine reads the latched status, writes the same value back to acknowledge exactly those sources, and then handles them from the lowest bit upward. The cascade line stays high while any unmasked status bit remains, which suits a level-triggered primary controller.

Top module: `board_irq_aggregator`

## Requirements
- R1: After reset the status, enable and mask registers all read 0x0000 and `cascade_irq` is low.
- R2: A write to the enable-set port (address 2) sets every enable bit where the write data has a 1; a write to the enable-clear port (address 3) clears every enable bit where the data has a 1; bits written with 0 keep their value.
- R3: A write to the mask-set port (address 4) sets mask bits (unmasks those sources) where the data has a 1; a write to the mask-clear port (address 5) clears mask bits (masks those sources) where the data has a 1; bits written with 0 keep their value.
- R4: A status bit becomes 1 on a rising clock edge where its request input is high and its enable bit is 1; a request from a disabled source never sets status.
- R5: A write to the status port (address 0) clears every status bit where the data has a 1 and leaves the other bits unchanged, so writing back a value just read acknowledges exactly those sources.
- R6: When a source's request is high and enabled on the same edge that a status write clears its bit, the bit stays 1.
- R7: `cascade_irq` is a register that is 1 on the edge after one where (status AND mask) is non-zero and 0 on the edge after one where it is zero; masked status bits never raise it.
- R8: Address 1 returns the status register and ignores writes; reads of addresses 2 and 3 return the enable register, reads of 4 and 5 return the mask register, reads of addresses 6 and 7 return 0x0000 and writes to them change nothing.
- R9: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd` and reflects register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Interrupt requests, bit k is source k, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 3 | Register address (0 status, 1 status view, 2/3 enable set/clear, 4/5 mask set/clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cascade_irq | output | 1 | Level cascade interrupt to the primary controller |

## Verification
The bench aims at requests from sources that are still disabled, which a design latching raw requests would turn into spurious status bits and a raised cascade line. It acknowledges a subset of the pending bits and a bit whose request is still active in the same cycle, so a design that cleared too much, too little, or let the clear beat the set would show the wrong status on read-back. It writes to the read-only view and to unused addresses, where a loose decoder would corrupt enable or mask, and it samples the cascade line on the exact edge it should rise and fall, so an unregistered or doubly delayed output fails.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS  = 3'd0,
    A_VIEW    = 3'd1,
    A_EN_SET  = 3'd2,
    A_EN_CLR  = 3'd3,
    A_MSK_SET = 3'd4,
    A_MSK_CLR = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ack;
    logic en_set;
    logic en_clr;
    logic msk_set;
    logic msk_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irq_setclr_reg.sv
`timescale 1ns/1ps
module irq_setclr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (set_we) begin
      q <= q | wdata;
    end else if (clr_we) begin
      q <= q & ~wdata;
    end
  end
endmodule

// File: rtl/irq_status_latch.sv
`timescale 1ns/1ps
module irq_status_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  input  logic [W-1:0] enable,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  output logic [W-1:0] status
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic hit;
    logic drop;
    assign hit  = req[k] & enable[k];
    assign drop = ack_we & ack_data[k];
    always_ff @(posedge clk) begin
      if (rst) begin
        status[k] <= 1'b0;
      end else if (hit) begin
        status[k] <= 1'b1;
      end else if (drop) begin
        status[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_agg_decode.sv
`timescale 1ns/1ps
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      enable,
  input  logic [W-1:0]      mask,
  output wr_strobe_t        stb,
  output logic [W-1:0]      rdata
);
  reg_addr_e addr;
  logic [W-1:0] rd_mux;

  assign addr = reg_addr_e'(bus_addr);

  always_comb begin
    stb = '0;
    if (bus_wr) begin
      case (addr)
        A_STATUS:  stb.ack     = 1'b1;
        A_EN_SET:  stb.en_set  = 1'b1;
        A_EN_CLR:  stb.en_clr  = 1'b1;
        A_MSK_SET: stb.msk_set = 1'b1;
        A_MSK_CLR: stb.msk_clr = 1'b1;
        default:   stb = '0;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_STATUS, A_VIEW:    rd_mux = status;
      A_EN_SET, A_EN_CLR:  rd_mux = enable;
      A_MSK_SET, A_MSK_CLR: rd_mux = mask;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_rd) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/board_irq_aggregator.sv
`timescale 1ns/1ps
module board_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               cascade_irq
);
  wr_strobe_t         stb;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] mask_q;

  irq_agg_decode #(.W(NUM_SRC)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .status   (status_q),
    .enable   (enable_q),
    .mask     (mask_q),
    .stb      (stb),
    .rdata    (bus_rdata)
  );

  irq_setclr_reg #(.W(NUM_SRC)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_we (stb.en_set),
    .clr_we (stb.en_clr),
    .wdata  (bus_wdata),
    .q      (enable_q)
  );

  irq_setclr_reg #(.W(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_we (stb.msk_set),
    .clr_we (stb.msk_clr),
    .wdata  (bus_wdata),
    .q      (mask_q)
  );

  irq_status_latch #(.W(NUM_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .req      (req_in),
    .enable   (enable_q),
    .ack_we   (stb.ack),
    .ack_data (bus_wdata),
    .status   (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cascade_irq <= 1'b0;
    end else begin
      cascade_irq <= |(status_q & mask_q);
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic [W-1:0] req_in,
  input logic [W-1:0] status,
  input logic [W-1:0] enable,
  input logic [W-1:0] mask,
  input logic         cascade_irq
);
  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $past(rst) |-> (cascade_irq == 1'b0 && status == '0 && enable == '0 && mask == '0));

  // R4
  no_disabled_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ~$past(enable)) == '0));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((~status & $past(req_in & enable)) == '0));

  // R7
  cascade_level_chk: assert property (@(posedge clk) disable iff (rst)
    cascade_irq == (|$past(status & mask)));

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(enable));
endmodule

bind board_irq_aggregator irq_agg_chk #(.W(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .req_in      (req_in),
  .status      (status_q),
  .enable      (enable_q),
  .mask        (mask_q),
  .cascade_irq (cascade_irq)
);

// File: tb/tb_board_irq_aggregator.sv
`timescale 1ns/1ps
module tb_board_irq_aggregator;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] req_in = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         cascade_irq;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;
  logic rd_q = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  board_irq_aggregator #(.NUM_SRC(W)) dut (
    .clk, .rst, .req_in, .bus_wr, .bus_rd, .bus_addr,
    .bus_wdata, .bus_rdata, .cascade_irq
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_q <= bus_rd;

  // monitor: rdata registered at the edge sampling bus_rd (R9)
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=unexpected_read expected=none");
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 cascade", {15'd0, cascade_irq}, 16'h0000);
    rd(3'd0, 16'h0000, "R1 status");
    rd(3'd2, 16'h0000, "R1 enable");
    rd(3'd4, 16'h0000, "R1 mask");

    // R4 disabled sources never latch
    @(negedge clk); req_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    req_in = '0;
    rd(3'd0, 16'h0000, "R4 disabled");
    check("R4 cascade", {15'd0, cascade_irq}, 16'h0000);

    // R2 enable set/clear
    wr(3'd2, 16'h00F0);
    wr(3'd2, 16'h0003);
    rd(3'd3, 16'h00F3, "R2 enable set");
    wr(3'd3, 16'h0010);
    rd(3'd2, 16'h00E3, "R2 enable clear");

    // R3 mask set/clear
    wr(3'd4, 16'h0021);
    wr(3'd5, 16'h0001);
    rd(3'd5, 16'h0020, "R3 mask");

    // R4 enabled sources latch
    @(negedge clk); req_in = 16'h00FF;
    @(negedge clk); req_in = '0;
    rd(3'd1, 16'h00E3, "R4 latch");
    check("R7 raised", {15'd0, cascade_irq}, 16'h0001);

    // R8 view is read-only
    wr(3'd1, 16'hFFFF);
    rd(3'd0, 16'h00E3, "R8 view write");

    // R5 acknowledge subsets
    wr(3'd0, 16'h0003);
    rd(3'd0, 16'h00E0, "R5 ack low bits");
    check("R7 still high", {15'd0, cascade_irq}, 16'h0001);
    wr(3'd0, 16'h0020);
    @(negedge clk);
    check("R7 masked bits", {15'd0, cascade_irq}, 16'h0000);
    rd(3'd0, 16'h00C0, "R5 ack unmasked");

    // R6 set wins over clear
    @(negedge clk);
    req_in = 16'h0080;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0080;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; req_in = '0;
    rd(3'd0, 16'h00C0, "R6 set wins");
    wr(3'd0, 16'h00C0);
    rd(3'd0, 16'h0000, "R5 write back");

    // R8 unused address
    wr(3'd6, 16'hFFFF);
    rd(3'd6, 16'h0000, "R8 unused read");
    rd(3'd3, 16'h00E3, "R8 enable intact");
    rd(3'd4, 16'h0020, "R8 mask intact");

    // R7 exact timing
    wr(3'd4, 16'hFFFF);
    @(negedge clk); req_in = 16'h0002;
    @(negedge clk); req_in = '0;
    check("R7 not yet", {15'd0, cascade_irq}, 16'h0000);
    @(negedge clk);
    check("R7 rise edge", {15'd0, cascade_irq}, 16'h0001);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    check("R7 still up", {15'd0, cascade_irq}, 16'h0001);
    @(negedge clk);
    check("R7 fall edge", {15'd0, cascade_irq}, 16'h0000);

    repeat (3) @(negedge clk);
    check("R9 drained", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule